// File: doc/BRIEF.md
# Pipelined-to-Peripheral Bus Bridge

This block sits between a pipelined high-performance system bus and a slow peripheral bus that shares its clock. Upstream it is a slave. It takes an address phase followed by a data phase, and it uses a ready output to stall the master. Downstream it is the only master. Every accepted upstream beat becomes one two-cycle peripheral access: a setup cycle, in which the address is decoded and a select rises, and then an enable cycle, in which the data moves. The downstream side never pipelines or bursts.

Writes are posted. The bridge keeps the write address and control from the address phase and takes the write data during the data phase. If the downstream sequencer is free, it releases the master at once. A second write that arrives right behind the first has its address held in a separate pending register. Its data phase is stalled until the running access reaches its enable cycle. Reads always stall. Ready stays low until the enable cycle of the read, and in that cycle the peripheral read data goes straight to the upstream read bus.

Address bits [15:12] pick one of four peripheral selects. Transfer types that do not request a transfer are ignored.

Top module: `pbb_bridge`

## Requirements
- R1: After a synchronous active-low reset, including a reset taken in the middle of an access, `up_ready` is 1, `dn_sel` is all zero and `dn_enable` is 0.
- R2: An address phase is accepted only in a cycle where `up_sel` is 1, `up_trans[1]` is 1 (2'b10 first beat, 2'b11 following beat) and `up_ready` is 1. Types 2'b00 (idle) and 2'b01 (busy), and any cycle with `up_sel` at 0, start no downstream access.
- R3: Each downstream access is exactly one setup cycle (a select high, `dn_enable` 0) followed by exactly one enable cycle (`dn_enable` 1). `dn_enable` is never high in two consecutive cycles.
- R4: `dn_addr`, `dn_write` and `dn_wdata` hold the same value from the setup cycle through the enable cycle. They keep that value until the next access starts.
- R5: Address bits [15:12] give a region. A region below 4 raises `dn_sel[region]` only. A region of 4 or more raises no select, and a read from it returns 0 on `up_rdata`, but it still takes the setup and enable cycles.
- R6: A write whose data phase finds the sequencer idle or in its enable cycle gets no wait state. Its setup cycle starts in the cycle after the data phase, with `dn_wdata` equal to the data presented in the data phase.
- R7: In a read data phase, `up_ready` stays 0 until the enable cycle of that read. It is 1 in that enable cycle, with `up_rdata` equal to `dn_rdata` in that same cycle. A read accepted from an idle bridge in cycle t completes in cycle t+3.
- R8: A write whose data phase meets the setup cycle of the previous access is stalled (`up_ready` 0) until that access reaches its enable cycle. The next setup cycle then follows the enable cycle directly, with no idle cycle between them.
- R9: From an enable cycle followed directly by a setup cycle, the select stays high when both accesses target the same region and moves to the new region otherwise. After the last access, all selects drop.
- R10: `up_rdata` is 0 in every cycle that does not complete a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both buses |
| rst_n | input | 1 | Synchronous active-low reset |
| up_sel | input | 1 | Upstream slave select for this bridge |
| up_trans | input | 2 | Upstream transfer type (bit 1 set means a transfer is requested) |
| up_write | input | 1 | Upstream direction, 1 = write |
| up_addr | input | ADDR_W | Upstream address, valid in the address phase |
| up_wdata | input | DATA_W | Upstream write data, valid in the data phase |
| up_ready | output | 1 | Data phase completes when 1, stalls the master when 0 |
| up_rdata | output | DATA_W | Upstream read data, valid when a read completes |
| dn_addr | output | ADDR_W | Downstream address, held for the whole access |
| dn_sel | output | NUM_PERIPH | One select per peripheral region |
| dn_enable | output | 1 | High in the enable cycle of an access |
| dn_write | output | 1 | Downstream direction, 1 = write |
| dn_wdata | output | DATA_W | Downstream write data |
| dn_rdata | input | DATA_W | Downstream read data, sampled in the enable cycle |

## Verification
Two things can happen in one cycle here. A running access can finish (a read returning data with ready high, or an enable cycle freeing the sequencer), and in that same cycle the next upstream address phase can be accepted, or the next write's data can be launched downstream. The stimulus table puts a new write address phase on the bus in the enable cycle of a read, then sends a second-beat write right behind the first, and the directed test chains two writes to different regions. Every cycle is judged by comparing ready, selects, enable, address, direction and read data against values worked out from the stated timing. This also checks that the finishing read's data does not leak into the next cycle and that the select moves straight from one region to the other.

// File: rtl/pbb_pkg.sv
// Package: shared types for the bus bridge.
// Assumes: both buses run on one clock; no error or split responses.
package pbb_pkg;

    // Downstream access phase
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ENABLE = 2'd2
    } phase_e;

    // Upstream data-phase slot state
    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,   // no data phase outstanding
        SLOT_WAIT  = 2'd1,   // data phase open, not yet launched downstream
        SLOT_RDISS = 2'd2    // read launched, waiting for its enable cycle
    } slot_e;

    // Transfer types with bit 1 set request a transfer
    function automatic logic trans_requests(input logic [1:0] trans);
        return trans[1];
    endfunction

endpackage

// File: rtl/pbb_front.sv
// Module: upstream front end.
// Accepts address phases and keeps them in one pending address register.
// Decides upstream ready for the open data phase and asks the sequencer
// to launch. Assumes the sequencer can take a new access when it is
// idle or in its enable cycle.
module pbb_front
    import pbb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_sel,
    input  logic [1:0]        up_trans,
    input  logic              up_write,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic              seq_free,
    input  logic              seq_enable,
    output logic              up_ready,
    output logic              launch,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_write,
    output logic              rd_done,
    output slot_e             slot
);

    slot_e             slot_q;
    logic [ADDR_W-1:0] addr_q;
    logic              write_q;
    logic              accept;

    // Ready for the data phase that is currently open
    always_comb begin
        case (slot_q)
            SLOT_WAIT:  up_ready = write_q & seq_free;
            SLOT_RDISS: up_ready = seq_enable;
            default:    up_ready = 1'b1;
        endcase
    end

    // Address phase acceptance and launch request
    always_comb begin
        accept  = up_sel & trans_requests(up_trans) & up_ready;
        launch  = (slot_q == SLOT_WAIT) & seq_free;
        rd_done = (slot_q == SLOT_RDISS) & seq_enable;
    end

    // Slot state and pending address register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q  <= SLOT_EMPTY;
            addr_q  <= '0;
            write_q <= 1'b0;
        end else if (up_ready) begin
            slot_q <= accept ? SLOT_WAIT : SLOT_EMPTY;
            if (accept) begin
                addr_q  <= up_addr;
                write_q <= up_write;
            end
        end else if (launch) begin
            slot_q <= SLOT_RDISS;
        end
    end

    assign req_addr  = addr_q;
    assign req_write = write_q;
    assign slot      = slot_q;

    // R8: a stall only happens while a data phase is open
    p_stall_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !up_ready |-> (slot_q != SLOT_EMPTY));

    // R7: a launched read completes in the cycle ready rises
    p_read_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == SLOT_RDISS && !up_ready) |=> (slot_q == SLOT_RDISS));

endmodule

// File: rtl/pbb_seq.sv
// Module: downstream access sequencer.
// Runs idle, setup and enable phases and holds the active address,
// direction and write data. Assumes launch is only raised while it is
// idle or in its enable cycle.
module pbb_seq
    import pbb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] wdata_in,
    output phase_e            phase,
    output logic [ADDR_W-1:0] addr_q,
    output logic              write_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              enable,
    output logic              seq_free,
    output logic              seq_enable
);

    phase_e phase_q;

    // Phase sequencing: setup always leads to enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            case (phase_q)
                PH_SETUP: phase_q <= PH_ENABLE;
                default:  phase_q <= launch ? PH_SETUP : PH_IDLE;
            endcase
        end
    end

    // Active access registers, loaded only at launch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            write_q <= 1'b0;
            wdata_q <= '0;
        end else if (launch) begin
            addr_q  <= req_addr;
            write_q <= req_write;
            if (req_write) begin
                wdata_q <= wdata_in;
            end
        end
    end

    // Phase decode for the front end and the port
    always_comb begin
        enable     = (phase_q == PH_ENABLE);
        seq_enable = (phase_q == PH_ENABLE);
        seq_free   = (phase_q == PH_IDLE) | (phase_q == PH_ENABLE);
    end

    assign phase = phase_q;

    // R3: enable only follows a setup cycle
    p_enable_after_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        enable |-> $past(phase_q == PH_SETUP));

    // R3: no two consecutive enable cycles
    p_no_enable_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> !enable);

    // R4: control and data stay put from setup into enable
    p_hold_ctrl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_ENABLE) |-> ($stable(addr_q) && $stable(write_q) && $stable(wdata_q)));

endmodule

// File: rtl/pbb_decode.sv
// Module: peripheral region decoder.
// Turns the region field into one select per peripheral while an access
// is active. Assumes NUM_PERIPH fits in the region field.
module pbb_decode #(
    parameter int SEL_W      = 4,
    parameter int NUM_PERIPH = 4
) (
    input  logic [SEL_W-1:0]      region,
    input  logic                  active,
    output logic [NUM_PERIPH-1:0] sel,
    output logic                  hit
);

    localparam logic [SEL_W:0] LIMIT = (SEL_W+1)'(NUM_PERIPH);

    // Region lies inside the mapped range
    always_comb begin
        hit = ({1'b0, region} < LIMIT);
    end

    // One compare per peripheral
    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_sel
        assign sel[i] = active & (region == SEL_W'(i));
    end

endmodule

// File: rtl/pbb_bridge.sv
// Module: top of the pipelined-to-peripheral bus bridge.
// Links the upstream front end, the access sequencer and the region
// decoder. Read data goes to the upstream bus with no register stage.
// Assumes one shared clock and a single upstream master.
module pbb_bridge
    import pbb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int NUM_PERIPH = 4,
    parameter int SEL_LSB    = 12,
    parameter int SEL_W      = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  up_sel,
    input  logic [1:0]            up_trans,
    input  logic                  up_write,
    input  logic [ADDR_W-1:0]     up_addr,
    input  logic [DATA_W-1:0]     up_wdata,
    output logic                  up_ready,
    output logic [DATA_W-1:0]     up_rdata,
    output logic [ADDR_W-1:0]     dn_addr,
    output logic [NUM_PERIPH-1:0] dn_sel,
    output logic                  dn_enable,
    output logic                  dn_write,
    output logic [DATA_W-1:0]     dn_wdata,
    input  logic [DATA_W-1:0]     dn_rdata
);

    logic              launch;
    logic [ADDR_W-1:0] req_addr;
    logic              req_write;
    logic              rd_done;
    logic              seq_free;
    logic              seq_enable;
    logic              hit;
    slot_e             slot;
    phase_e            phase;

    pbb_front #(.ADDR_W(ADDR_W)) u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .up_sel     (up_sel),
        .up_trans   (up_trans),
        .up_write   (up_write),
        .up_addr    (up_addr),
        .seq_free   (seq_free),
        .seq_enable (seq_enable),
        .up_ready   (up_ready),
        .launch     (launch),
        .req_addr   (req_addr),
        .req_write  (req_write),
        .rd_done    (rd_done),
        .slot       (slot)
    );

    pbb_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .req_addr   (req_addr),
        .req_write  (req_write),
        .wdata_in   (up_wdata),
        .phase      (phase),
        .addr_q     (dn_addr),
        .write_q    (dn_write),
        .wdata_q    (dn_wdata),
        .enable     (dn_enable),
        .seq_free   (seq_free),
        .seq_enable (seq_enable)
    );

    pbb_decode #(.SEL_W(SEL_W), .NUM_PERIPH(NUM_PERIPH)) u_decode (
        .region (dn_addr[SEL_LSB +: SEL_W]),
        .active (phase != PH_IDLE),
        .sel    (dn_sel),
        .hit    (hit)
    );

    // Upstream read data: passed through only when a mapped read completes
    always_comb begin
        up_rdata = (rd_done && hit) ? dn_rdata : '0;
    end

    // R7: read completion coincides with a downstream read enable cycle
    p_ready_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_RDISS && up_ready) |-> (dn_enable && !dn_write));

    // R9: no select while the sequencer is idle
    p_idle_nosel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> (dn_sel == '0));

    // R5: at most one select at a time
    p_sel_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dn_sel));

endmodule

// File: tb/pbb_bridge_bench.sv
// Bench: a cycle table walked by one loop, then directed tests.
module pbb_bridge_bench;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int NP = 4;
    localparam int ROWS = 14;
    localparam int VW = 91;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          up_sel = 1'b0;
    logic [1:0]    up_trans = 2'b00;
    logic          up_write = 1'b0;
    logic [AW-1:0] up_addr = '0;
    logic [DW-1:0] up_wdata = '0;
    logic          up_ready;
    logic [DW-1:0] up_rdata;
    logic [AW-1:0] dn_addr;
    logic [NP-1:0] dn_sel;
    logic          dn_enable;
    logic          dn_write;
    logic [DW-1:0] dn_wdata;
    logic [DW-1:0] dn_rdata = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    pbb_bridge u_pbb_bridge (
        .clk(clk), .rst_n(rst_n), .up_sel(up_sel), .up_trans(up_trans),
        .up_write(up_write), .up_addr(up_addr), .up_wdata(up_wdata),
        .up_ready(up_ready), .up_rdata(up_rdata), .dn_addr(dn_addr),
        .dn_sel(dn_sel), .dn_enable(dn_enable), .dn_write(dn_write),
        .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
    );

    always #2 clk = ~clk;

    // Row: {sel,trans,write,addr,wdata,rdata_in | ready,sel4,en,wr,addr,rdata}
    localparam logic [VW-1:0] TBL [0:ROWS-1] = '{
        {1'b1,2'b10,1'b1,16'h1004,16'h0000,16'h0000, 1'b1,4'b0000,1'b0,1'b0,16'h0000,16'h0000},
        {1'b0,2'b00,1'b0,16'h0000,16'h00A1,16'h0000, 1'b1,4'b0000,1'b0,1'b0,16'h0000,16'h0000},
        {1'b0,2'b00,1'b0,16'h0000,16'h0000,16'h0000, 1'b1,4'b0010,1'b0,1'b1,16'h1004,16'h0000},
        {1'b0,2'b00,1'b0,16'h0000,16'h0000,16'h0000, 1'b1,4'b0010,1'b1,1'b1,16'h1004,16'h0000},
        {1'b1,2'b10,1'b0,16'h2008,16'h0000,16'h0000, 1'b1,4'b0000,1'b0,1'b1,16'h1004,16'h0000},
        {1'b0,2'b00,1'b0,16'h0000,16'h0000,16'h0000, 1'b0,4'b0000,1'b0,1'b1,16'h1004,16'h0000},
        {1'b0,2'b00,1'b0,16'h0000,16'h0000,16'h5555, 1'b0,4'b0100,1'b0,1'b0,16'h2008,16'h0000},
        {1'b1,2'b10,1'b1,16'h3010,16'h0000,16'h7E7E, 1'b1,4'b0100,1'b1,1'b0,16'h2008,16'h7E7E},
        {1'b1,2'b11,1'b1,16'h3014,16'h00B2,16'h7E7E, 1'b1,4'b0000,1'b0,1'b0,16'h2008,16'h0000},
        {1'b0,2'b00,1'b0,16'h0000,16'h00C3,16'h0000, 1'b0,4'b1000,1'b0,1'b1,16'h3010,16'h0000},
        {1'b0,2'b00,1'b0,16'h0000,16'h00C3,16'h0000, 1'b1,4'b1000,1'b1,1'b1,16'h3010,16'h0000},
        {1'b0,2'b00,1'b0,16'h0000,16'h0000,16'h0000, 1'b1,4'b1000,1'b0,1'b1,16'h3014,16'h0000},
        {1'b0,2'b00,1'b0,16'h0000,16'h0000,16'h0000, 1'b1,4'b1000,1'b1,1'b1,16'h3014,16'h0000},
        {1'b0,2'b00,1'b0,16'h0000,16'h0000,16'h0000, 1'b1,4'b0000,1'b0,1'b1,16'h3014,16'h0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp_v);
        end
    endtask

    // Drive one upstream cycle at the falling edge; outputs sampled 1 ns later
    task automatic drive(input logic s, input logic [1:0] tr, input logic w,
                         input logic [31:0] a, input logic [31:0] wd);
        @(negedge clk);
        up_sel = s; up_trans = tr; up_write = w; up_addr = a; up_wdata = wd;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            finish_run();
        end
    end

    initial begin
        logic        s, w, e_rdy, e_en, e_wr;
        logic [1:0]  tr;
        logic [15:0] a, wd, rd, e_a, e_rd;
        logic [3:0]  e_sel;

        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 ready", {31'd0, up_ready}, 32'd1);
        chk("R1 sel", {28'd0, dn_sel}, 32'd0);
        chk("R1 enable", {31'd0, dn_enable}, 32'd0);
        chk("R10 rdata", up_rdata, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table: single write, read overlapped with next address, chained writes
        for (int i = 0; i < ROWS; i++) begin
            {s, tr, w, a, wd, rd, e_rdy, e_sel, e_en, e_wr, e_a, e_rd} = TBL[i];
            @(negedge clk);
            up_sel = s; up_trans = tr; up_write = w;
            up_addr = {16'd0, a}; up_wdata = {16'd0, wd}; dn_rdata = {16'd0, rd};
            #1;
            chk("R6/R7/R8 ready", {31'd0, up_ready}, {31'd0, e_rdy});
            chk("R5/R9 sel", {28'd0, dn_sel}, {28'd0, e_sel});
            chk("R3 enable", {31'd0, dn_enable}, {31'd0, e_en});
            chk("R4 write", {31'd0, dn_write}, {31'd0, e_wr});
            chk("R4 addr", dn_addr, {16'd0, e_a});
            chk("R7/R10 rdata", up_rdata, {16'd0, e_rd});
            if (i == 2) chk("R6 wdata", dn_wdata, 32'h00A1);
            if (i == 9) chk("R8 wdata", dn_wdata, 32'h00B2);
            if (i == 11) chk("R8 wdata", dn_wdata, 32'h00C3);
        end

        // R2: busy type, idle type and deselected requests are ignored
        drive(1'b1, 2'b01, 1'b1, 32'h1000, 32'h0);
        drive(1'b1, 2'b00, 1'b1, 32'h1000, 32'h0);
        drive(1'b0, 2'b10, 1'b1, 32'h1000, 32'h0);
        for (int k = 0; k < 3; k++) begin
            drive(1'b0, 2'b00, 1'b0, 32'h0, 32'h0);
            chk("R2 no enable", {31'd0, dn_enable}, 32'd0);
            chk("R2 no sel", {28'd0, dn_sel}, 32'd0);
            chk("R2 ready", {31'd0, up_ready}, 32'd1);
        end

        // R5: unmapped region read, no select, zero data, normal timing
        dn_rdata = 32'hFFFF_FFFF;
        drive(1'b1, 2'b10, 1'b0, 32'h5000, 32'h0);
        chk("R7 ready addr phase", {31'd0, up_ready}, 32'd1);
        drive(1'b0, 2'b00, 1'b0, 32'h0, 32'h0);
        chk("R7 stall", {31'd0, up_ready}, 32'd0);
        drive(1'b0, 2'b00, 1'b0, 32'h0, 32'h0);
        chk("R5 unmapped setup sel", {28'd0, dn_sel}, 32'd0);
        chk("R7 stall setup", {31'd0, up_ready}, 32'd0);
        drive(1'b0, 2'b00, 1'b0, 32'h0, 32'h0);
        chk("R7 done t+3", {31'd0, up_ready}, 32'd1);
        chk("R3 unmapped enable", {31'd0, dn_enable}, 32'd1);
        chk("R5 unmapped sel", {28'd0, dn_sel}, 32'd0);
        chk("R5 unmapped rdata", up_rdata, 32'd0);
        dn_rdata = '0;
        drive(1'b0, 2'b00, 1'b0, 32'h0, 32'h0);

        // R9: chained writes to different regions, select moves directly
        drive(1'b1, 2'b10, 1'b1, 32'h0000, 32'h0);
        drive(1'b1, 2'b10, 1'b1, 32'h2000, 32'h11);
        chk("R6 no wait first", {31'd0, up_ready}, 32'd1);
        drive(1'b0, 2'b00, 1'b0, 32'h0, 32'h22);
        chk("R8 stall in setup", {31'd0, up_ready}, 32'd0);
        chk("R9 sel first", {28'd0, dn_sel}, 32'b0001);
        chk("R6 wdata first", dn_wdata, 32'h11);
        drive(1'b0, 2'b00, 1'b0, 32'h0, 32'h22);
        chk("R8 release in enable", {31'd0, up_ready}, 32'd1);
        chk("R3 enable first", {31'd0, dn_enable}, 32'd1);
        drive(1'b0, 2'b00, 1'b0, 32'h0, 32'h0);
        chk("R9 sel moved", {28'd0, dn_sel}, 32'b0100);
        chk("R8 direct setup", {31'd0, dn_enable}, 32'd0);
        chk("R4 addr second", dn_addr, 32'h2000);
        chk("R6 wdata second", dn_wdata, 32'h22);
        drive(1'b0, 2'b00, 1'b0, 32'h0, 32'h0);
        chk("R3 enable second", {31'd0, dn_enable}, 32'd1);
        drive(1'b0, 2'b00, 1'b0, 32'h0, 32'h0);
        chk("R9 sel dropped", {28'd0, dn_sel}, 32'd0);

        // R1: reset taken during a setup cycle
        drive(1'b1, 2'b10, 1'b1, 32'h1000, 32'h0);
        drive(1'b0, 2'b00, 1'b0, 32'h0, 32'h33);
        drive(1'b0, 2'b00, 1'b0, 32'h0, 32'h0);
        chk("R3 setup before reset", {28'd0, dn_sel}, 32'b0010);
        rst_n = 1'b0;
        drive(1'b0, 2'b00, 1'b0, 32'h0, 32'h0);
        chk("R1 mid reset sel", {28'd0, dn_sel}, 32'd0);
        chk("R1 mid reset enable", {31'd0, dn_enable}, 32'd0);
        chk("R1 mid reset ready", {31'd0, up_ready}, 32'd1);
        rst_n = 1'b1;
        drive(1'b0, 2'b00, 1'b0, 32'h0, 32'h0);
        chk("R1 stays idle", {31'd0, dn_enable}, 32'd0);

        finish_run();
    end

endmodule